// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register file is divided into overlapping windows. Thirty-two architectural register numbers are visible at any time. Eight of them are globals shared by every window. The other twenty-four are resolved through a current-window pointer into a physical array of 8 + 16×NWIN words. Each window owns eight locals and eight ins. Its eight outs are the ins of the window below it, so a caller's outs become the callee's ins with no copy.

A window-invalid mask marks windows that may not be entered. A save request moves the pointer down by one and a restore request moves it up by one, both modulo NWIN. A request whose target window is marked invalid leaves the pointer alone and emits a one-cycle overflow or underflow pulse that carries the target window number.

A save or restore also adds the values on the two read ports, which are resolved in the old window. It writes the sum to the destination register, which is resolved in the new window. The pointer and the mask can be loaded directly. A pointer value outside the window range is refused and flagged.

Top module: `winreg_file`

## Requirements
- R1: After reset, `cwp` is 0, `wim` has only bit 1 set, both trap outputs and `cwp_bad` are 0, and every register 0..31 reads 0.
- R2: Register numbers 1..7 address globals that are the same storage in every window. Register numbers 8..15 are the outs, 16..23 the locals and 24..31 the ins of the window given by `cwp`. Locals and ins are private to each window.
- R3: Out register 8+k of window w is the same storage as in register 24+k of window (w−1) mod NWIN. This includes the wrap: the outs of window 0 are the ins of window NWIN−1.
- R4: Register 0 reads as zero on both read ports, and writes to it are ignored.
- R5: When `win_save` is high and bit (cwp−1) mod NWIN of `wim` is clear, `cwp` takes that value on the next clock edge.
- R6: When `win_restore` is high alone and bit (cwp+1) mod NWIN of `wim` is clear, `cwp` takes that value on the next clock edge.
- R7: A save whose target mask bit is set leaves `cwp` unchanged and writes no register. In the cycle after the request, `ovf_trap` is high for exactly one cycle and `trap_win` holds the target window.
- R8: A restore whose target mask bit is set leaves `cwp` unchanged and writes no register. In the cycle after the request, `unf_trap` is high for exactly one cycle and `trap_win` holds the target window.
- R9: A successful save or restore writes `rs_a_val + rs_b_val`, both read in the old window, to register `win_dest` resolved in the new window.
- R10: With no window request, `cwp_set` loads `cwp_set_val` if it is below NWIN. Otherwise `cwp` is unchanged and `cwp_bad` is high for one cycle.
- R11: When save and restore are both high, the save is performed. During any window request the plain write port and `cwp_set` are ignored.
- R12: A plain write (`wr_en`) and a mask load (`wim_set`) take effect at the next clock edge and are visible through the read ports and `wim` right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs_a_idx | input | 5 | Read port A register number |
| rs_a_val | output | XLEN | Read port A data |
| rs_b_idx | input | 5 | Read port B register number |
| rs_b_val | output | XLEN | Read port B data |
| wr_en | input | 1 | Plain write enable |
| wr_idx | input | 5 | Plain write register number |
| wr_val | input | XLEN | Plain write data |
| win_save | input | 1 | Save request |
| win_restore | input | 1 | Restore request |
| win_dest | input | 5 | Destination register for the save/restore sum |
| cwp_set | input | 1 | Load current-window pointer |
| cwp_set_val | input | 5 | Requested pointer value |
| wim_set | input | 1 | Load window-invalid mask |
| wim_set_val | input | NWIN | New mask |
| cwp | output | clog2(NWIN) | Current-window pointer |
| wim | output | NWIN | Window-invalid mask |
| ovf_trap | output | 1 | Window overflow pulse |
| unf_trap | output | 1 | Window underflow pulse |
| trap_win | output | clog2(NWIN) | Target window of the last trap |
| cwp_bad | output | 1 | Out-of-range pointer load pulse |

## Verification
The bench builds the block with NWIN = 4, so the physical array holds 72 words. It writes a distinct value into every local and in of every window and then reads all 31 nonzero registers back from every window. This covers each overlap, including the wrap from window 0 to window 3. The small window count also lets save and restore chains walk the whole ring in both directions, and it puts every pointer value from 4 to 31 out of range.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam int ARCH_IDX_W  = 5;
    localparam int CWP_FIELD_W = 5;
    localparam int BANK_REGS   = 8;
    localparam int WIN_WORDS   = 2 * BANK_REGS;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

endpackage

// File: rtl/winreg_map.sv
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CWW  = 3,
    parameter int PW   = 8
) (
    input  logic [ARCH_IDX_W-1:0] arch_idx,
    input  logic [CWW-1:0]        win,
    output logic [PW-1:0]         phys_idx
);

    reg_grp_e grp;
    logic [2:0] slot;
    int unsigned below_win;
    int unsigned phys_int;

    always_comb begin
        grp       = reg_grp_e'(arch_idx[4:3]);
        slot      = arch_idx[2:0];
        below_win = (int'(win) == 0) ? unsigned'(NWIN - 1) : unsigned'(int'(win) - 1);
        case (grp)
            GRP_GLOBAL: phys_int = 32'(slot);
            GRP_IN:     phys_int = BANK_REGS + WIN_WORDS * 32'(win) + 32'(slot);
            GRP_LOCAL:  phys_int = BANK_REGS + WIN_WORDS * 32'(win) + BANK_REGS + 32'(slot);
            default:    phys_int = BANK_REGS + WIN_WORDS * below_win + 32'(slot);
        endcase
        phys_idx = phys_int[PW-1:0];
    end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CWW  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   save_req,
    input  logic                   restore_req,
    input  logic                   cwp_set,
    input  logic [CWP_FIELD_W-1:0] cwp_set_val,
    input  logic                   wim_set,
    input  logic [NWIN-1:0]        wim_set_val,
    output logic [CWW-1:0]         cwp_q_o,
    output logic [NWIN-1:0]        wim_q_o,
    output logic [CWW-1:0]         op_tgt_o,
    output logic                   op_go_o,
    output logic                   ovf_q_o,
    output logic                   unf_q_o,
    output logic [CWW-1:0]         twin_q_o,
    output logic                   bad_q_o
);

    typedef struct packed {
        logic [CWW-1:0]  cwp;
        logic [NWIN-1:0] wim;
        logic            ovf;
        logic            unf;
        logic [CWW-1:0]  twin;
        logic            bad;
    } ctl_t;

    localparam logic [CWW-1:0] LAST_WIN = CWW'(NWIN - 1);

    ctl_t ctl_d, ctl_q;
    logic [CWW-1:0] sv_tgt, rs_tgt, op_tgt;
    logic op_req, op_ok;

    always_comb begin
        sv_tgt = (ctl_q.cwp == '0) ? LAST_WIN : ctl_q.cwp - 1'b1;
        rs_tgt = (ctl_q.cwp == LAST_WIN) ? '0 : ctl_q.cwp + 1'b1;
        op_tgt = save_req ? sv_tgt : rs_tgt;
        op_req = save_req || restore_req;
        op_ok  = op_req && !ctl_q.wim[op_tgt];

        ctl_d      = ctl_q;
        ctl_d.ovf  = 1'b0;
        ctl_d.unf  = 1'b0;
        ctl_d.bad  = 1'b0;
        if (op_req) begin
            if (op_ok) begin
                ctl_d.cwp = op_tgt;
            end else begin
                ctl_d.ovf  = save_req;
                ctl_d.unf  = !save_req;
                ctl_d.twin = op_tgt;
            end
        end else if (cwp_set) begin
            if (32'(cwp_set_val) < NWIN) begin
                ctl_d.cwp = cwp_set_val[CWW-1:0];
            end else begin
                ctl_d.bad = 1'b1;
            end
        end
        if (wim_set) begin
            ctl_d.wim = wim_set_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cwp  <= '0;
            ctl_q.wim  <= NWIN'(2);
            ctl_q.ovf  <= 1'b0;
            ctl_q.unf  <= 1'b0;
            ctl_q.twin <= '0;
            ctl_q.bad  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cwp_q_o  = ctl_q.cwp;
    assign wim_q_o  = ctl_q.wim;
    assign op_tgt_o = op_tgt;
    assign op_go_o  = op_ok;
    assign ovf_q_o  = ctl_q.ovf;
    assign unf_q_o  = ctl_q.unf;
    assign twin_q_o = ctl_q.twin;
    assign bad_q_o  = ctl_q.bad;

    p_cwp_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ctl_q.cwp) < NWIN);
    p_single_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.ovf && ctl_q.unf));
    p_trap_keeps_cwp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovf || ctl_q.unf) |-> ctl_q.cwp == $past(ctl_q.cwp));
    p_save_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !ctl_q.wim[sv_tgt]) |=> ctl_q.cwp == $past(sv_tgt));
    p_restore_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_req && restore_req && !ctl_q.wim[rs_tgt]) |=> ctl_q.cwp == $past(rs_tgt));
    p_bad_keeps_cwp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.bad |-> ctl_q.cwp == $past(ctl_q.cwp));

endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int DEPTH = 136,
    parameter int PW    = 8,
    parameter int XLEN  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   ra_idx,
    output logic [XLEN-1:0] ra_val,
    input  logic [PW-1:0]   rb_idx,
    output logic [XLEN-1:0] rb_val,
    input  logic            we,
    input  logic [PW-1:0]   wa_idx,
    input  logic [XLEN-1:0] wa_val
);

    logic [XLEN-1:0] mem_d [DEPTH];
    logic [XLEN-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && wa_idx != '0 && 32'(wa_idx) < DEPTH) begin
            mem_d[wa_idx] = wa_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ra_val = (ra_idx == '0 || 32'(ra_idx) >= DEPTH) ? '0 : mem_q[ra_idx];
    assign rb_val = (rb_idx == '0 || 32'(rb_idx) >= DEPTH) ? '0 : mem_q[rb_idx];

    p_r0_cell_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[0] == '0);

endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rs_a_idx,
    output logic [XLEN-1:0]         rs_a_val,
    input  logic [4:0]              rs_b_idx,
    output logic [XLEN-1:0]         rs_b_val,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [XLEN-1:0]         wr_val,
    input  logic                    win_save,
    input  logic                    win_restore,
    input  logic [4:0]              win_dest,
    input  logic                    cwp_set,
    input  logic [4:0]              cwp_set_val,
    input  logic                    wim_set,
    input  logic [NWIN-1:0]         wim_set_val,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic [NWIN-1:0]         wim,
    output logic                    ovf_trap,
    output logic                    unf_trap,
    output logic [$clog2(NWIN)-1:0] trap_win,
    output logic                    cwp_bad
);

    localparam int CWW   = $clog2(NWIN);
    localparam int DEPTH = BANK_REGS + WIN_WORDS * NWIN;
    localparam int PW    = $clog2(DEPTH);
    localparam int NMAP  = 4;

    logic [CWW-1:0]        cwp_q, op_tgt;
    logic                  op_go, op_req;
    logic [ARCH_IDX_W-1:0] map_arch [NMAP];
    logic [CWW-1:0]        map_win  [NMAP];
    logic [PW-1:0]         map_phys [NMAP];
    logic                  st_we;
    logic [PW-1:0]         st_wa;
    logic [XLEN-1:0]       st_wd;

    winreg_ctrl #(.NWIN(NWIN), .CWW(CWW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (win_save),
        .restore_req (win_restore),
        .cwp_set     (cwp_set),
        .cwp_set_val (cwp_set_val),
        .wim_set     (wim_set),
        .wim_set_val (wim_set_val),
        .cwp_q_o     (cwp_q),
        .wim_q_o     (wim),
        .op_tgt_o    (op_tgt),
        .op_go_o     (op_go),
        .ovf_q_o     (ovf_trap),
        .unf_q_o     (unf_trap),
        .twin_q_o    (trap_win),
        .bad_q_o     (cwp_bad)
    );

    assign op_req = win_save || win_restore;

    always_comb begin
        map_arch[0] = rs_a_idx;  map_win[0] = cwp_q;
        map_arch[1] = rs_b_idx;  map_win[1] = cwp_q;
        map_arch[2] = wr_idx;    map_win[2] = cwp_q;
        map_arch[3] = win_dest;  map_win[3] = op_tgt;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        winreg_map #(.NWIN(NWIN), .CWW(CWW), .PW(PW)) i_map (
            .arch_idx (map_arch[g]),
            .win      (map_win[g]),
            .phys_idx (map_phys[g])
        );
    end

    always_comb begin
        st_we = op_go || (wr_en && !op_req);
        st_wa = op_go ? map_phys[3] : map_phys[2];
        st_wd = op_go ? (rs_a_val + rs_b_val) : wr_val;
    end

    winreg_store #(.DEPTH(DEPTH), .PW(PW), .XLEN(XLEN)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (map_phys[0]),
        .ra_val (rs_a_val),
        .rb_idx (map_phys[1]),
        .rb_val (rs_b_val),
        .we     (st_we),
        .wa_idx (st_wa),
        .wa_val (st_wd)
    );

    assign cwp = cwp_q;

    p_no_write_on_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_go) |-> !st_we);

endmodule

// File: tb/test_winreg_file.sv
module test_winreg_file;

    localparam int N    = 4;
    localparam int CWW  = 2;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rs_a_idx = '0, rs_b_idx = '0, wr_idx = '0, win_dest = '0, cwp_set_val = '0;
    logic [XLEN-1:0] rs_a_val, rs_b_val, wr_val = '0;
    logic wr_en = 1'b0, win_save = 1'b0, win_restore = 1'b0, cwp_set = 1'b0, wim_set = 1'b0;
    logic [N-1:0] wim_set_val = '0, wim;
    logic [CWW-1:0] cwp, trap_win;
    logic ovf_trap, unf_trap, cwp_bad;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    winreg_file #(.NWIN(N), .XLEN(XLEN)) i_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rs_a_idx(rs_a_idx), .rs_a_val(rs_a_val),
        .rs_b_idx(rs_b_idx), .rs_b_val(rs_b_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .win_save(win_save), .win_restore(win_restore), .win_dest(win_dest),
        .cwp_set(cwp_set), .cwp_set_val(cwp_set_val),
        .wim_set(wim_set), .wim_set_val(wim_set_val),
        .cwp(cwp), .wim(wim), .ovf_trap(ovf_trap), .unf_trap(unf_trap),
        .trap_win(trap_win), .cwp_bad(cwp_bad)
    );

    function automatic logic [31:0] pat(int w, int r);
        return 32'hA500_0000 | (32'(w) << 8) | 32'(r);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(int r, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(r); wr_val = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rreg(int r, output logic [31:0] v);
        @(negedge clk);
        rs_a_idx = 5'(r);
        #1 v = rs_a_val;
    endtask

    task automatic setcwp(int v);
        @(negedge clk);
        cwp_set = 1'b1; cwp_set_val = 5'(v);
        @(posedge clk); #1;
        cwp_set = 1'b0;
    endtask

    task automatic setwim(logic [N-1:0] m);
        @(negedge clk);
        wim_set = 1'b1; wim_set_val = m;
        @(posedge clk); #1;
        wim_set = 1'b0;
    endtask

    task automatic winop(bit s, bit r, int dst, int a, int b);
        @(negedge clk);
        win_save = s; win_restore = r; win_dest = 5'(dst);
        rs_a_idx = 5'(a); rs_b_idx = 5'(b);
        @(posedge clk); #1;
        win_save = 1'b0; win_restore = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 cwp", 32'(cwp), 0);
        chk("R1 wim", 32'(wim), 32'h2);
        chk("R1 traps", {29'd0, ovf_trap, unf_trap, cwp_bad}, 0);
        for (int r = 0; r < 32; r++) begin
            rreg(r, v);
            chk("R1 reg clear", v, 0);
        end

        // R12 mask load
        setwim('0);
        chk("R12 wim load", 32'(wim), 0);

        // R2/R3 sweep: fill locals and ins of each window, globals once
        for (int g = 1; g < 8; g++) wreg(g, pat(9, g));
        for (int w = 0; w < N; w++) begin
            setcwp(w);
            for (int r = 16; r < 32; r++) wreg(r, pat(w, r));
        end
        for (int w = 0; w < N; w++) begin
            setcwp(w);
            chk("R10 cwp load", 32'(cwp), 32'(w));
            for (int r = 1; r < 32; r++) begin
                rreg(r, v);
                if (r < 8) chk("R2 global", v, pat(9, r));
                else if (r < 16) chk("R3 outs overlap", v, pat((w + N - 1) % N, r + 16));
                else chk("R2 local/in", v, pat(w, r));
            end
        end

        // R3 write through outs, read as ins of window below (wrap at 0)
        setcwp(0);
        wreg(9, 32'h0BAD_F00D);
        setcwp(N - 1);
        rreg(25, v);
        chk("R3 wrap outs->ins", v, 32'h0BAD_F00D);

        // R4 register zero
        wreg(0, 32'hFFFF_FFFF);
        rreg(0, v);
        chk("R4 read a", v, 0);
        @(negedge clk) rs_b_idx = 5'd0;
        #1 chk("R4 read b", rs_b_val, 0);

        // R5 save chain around the ring
        setcwp(0);
        for (int i = 1; i <= N; i++) begin
            winop(1, 0, 0, 0, 0);
            chk("R5 save step", 32'(cwp), 32'((N - (i % N)) % N));
        end
        // R6 restore chain
        for (int i = 1; i <= N; i++) begin
            winop(0, 1, 0, 0, 0);
            chk("R6 restore step", 32'(cwp), 32'(i % N));
        end

        // R9 save/restore sum across windows
        setcwp(2);
        wreg(16, 32'd1000);
        wreg(25, 32'd234);
        winop(1, 0, 17, 16, 25);
        chk("R9 save cwp", 32'(cwp), 1);
        rreg(17, v);
        chk("R9 save sum in new window", v, 32'd1234);
        winop(0, 1, 8, 17, 0);
        chk("R9 restore cwp", 32'(cwp), 2);
        rreg(8, v);
        chk("R9 restore sum", v, 32'd1234);
        rreg(16, v);
        chk("R9 old local kept", v, 32'd1000);
        setcwp(1);
        rreg(24, v);
        chk("R9 sum via overlap", v, 32'd1234);

        // R7 overflow trap
        setwim(4'b0010);
        setcwp(2);
        rreg(17, v);
        winop(1, 0, 17, 0, 0);
        chk("R7 ovf pulse", {30'd0, ovf_trap, unf_trap}, 32'h2);
        chk("R7 trap_win", 32'(trap_win), 1);
        chk("R7 cwp held", 32'(cwp), 2);
        @(posedge clk); #1;
        chk("R7 ovf one cycle", 32'(ovf_trap), 0);
        setcwp(1);
        setcwp(2);
        winop(0, 1, 0, 0, 0);
        chk("R6 restore 2->3", 32'(cwp), 3);
        // check window 1 local 17 untouched by the trapping save
        wim_set_val = '0; setwim('0); setcwp(1);
        rreg(17, v);
        chk("R7 no write", v, 32'd1234);

        // R8 underflow trap
        setwim(4'b0010);
        setcwp(0);
        winop(0, 1, 20, 0, 0);
        chk("R8 unf pulse", {30'd0, ovf_trap, unf_trap}, 32'h1);
        chk("R8 trap_win", 32'(trap_win), 1);
        chk("R8 cwp held", 32'(cwp), 0);
        @(posedge clk); #1;
        chk("R8 unf one cycle", 32'(unf_trap), 0);
        rreg(20, v);
        chk("R8 no write", v, pat(0, 20));

        // R10 illegal pointer values
        setwim('0);
        setcwp(3);
        for (int bad = N; bad < 32; bad++) begin
            setcwp(bad);
            chk("R10 bad flag", 32'(cwp_bad), 1);
            chk("R10 cwp held", 32'(cwp), 3);
        end
        @(posedge clk); #1;
        chk("R10 flag one cycle", 32'(cwp_bad), 0);

        // R11 priority
        setcwp(2);
        winop(1, 1, 0, 0, 0);
        chk("R11 save wins", 32'(cwp), 1);
        wreg(5, 32'h5555_0005);
        @(negedge clk);
        win_save = 1'b1; win_dest = 5'd0; rs_a_idx = 5'd0; rs_b_idx = 5'd0;
        wr_en = 1'b1; wr_idx = 5'd5; wr_val = 32'hDEAD_0005;
        cwp_set = 1'b1; cwp_set_val = 5'd3;
        @(posedge clk); #1;
        win_save = 1'b0; wr_en = 1'b0; cwp_set = 1'b0;
        chk("R11 cwp_set ignored", 32'(cwp), 0);
        rreg(5, v);
        chk("R11 plain write ignored", v, 32'h5555_0005);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule